// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

A synchronous two-port memory in which each side carries its own enable, output enable, write strobe, address and data. Either side may read or write any word whatever the other side is doing. When both sides select the same word, an arbiter picks a winner and raises a busy flag toward the other side. A write from a flagged side is dropped.

A parameter sets the role of an instance. A master carries the arbiter and drives the busy flags out. A slave has no arbiter: it takes both busy flags from a master and applies them to its own writes. Several instances that share address and control can therefore be placed side by side to make a wider word, with every slice making the same choice. A side whose enable is low is in standby. It makes no access and its read output is held at zero.

Top module: `dpram_arb`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits (default 2048 x 8). A write on one side (enable 1, write strobe 1, not blocked) can be read back from either side.
- R2: A side with enable 1, output enable 1 and write strobe 0 at a clock edge presents `*_rvalid_o`=1 after that edge. Its `*_rdata_o` then carries the word as it was before the edge. Otherwise `*_rvalid_o`=0 and `*_rdata_o`=0.
- R3: A side with enable 0 is in standby. Its write strobe has no effect on the array, and its `*_rvalid_o`/`*_rdata_o` read 0 after the edge.
- R4: In master role, contention means both enables are 1 and both addresses are equal. Busy (active high) goes to the losing side only, in the same cycle, and stays set while contention lasts and neither side starts a new access.
- R5: A side starts an access in a cycle when its enable is 1 and either its enable was 0 or its address was different in the previous cycle. The side whose access started in an earlier cycle wins.
- R6: When both sides start in the same cycle, the left side wins and `r_busy_o` is set.
- R7: A write from a side whose busy is set is dropped, and the word keeps its old value.
- R8: When both sides read the same word, both reads return that word, whatever the busy flags are.
- R9: While the winner writes a word that the loser is reading, the loser's read returns the old value. The loser's first read after contention ends returns the winner's new data.
- R10: In slave role (IS_MASTER=0), `l_busy_o` and `r_busy_o` stay 0, and a busy input of 1 drops that side's write.
- R11: In master role the busy inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_i | input | 1 | Left enable |
| l_oe_i | input | 1 | Left output enable |
| l_we_i | input | 1 | Left write strobe (1 = write) |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_busy_i | input | 1 | Left busy from a master (slave role) |
| l_busy_o | output | 1 | Left busy flag (master role) |
| l_rvalid_o | output | 1 | Left read output enabled |
| l_rdata_o | output | DATA_W | Left read data |
| r_ce_i | input | 1 | Right enable |
| r_oe_i | input | 1 | Right output enable |
| r_we_i | input | 1 | Right write strobe (1 = write) |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_busy_i | input | 1 | Right busy from a master (slave role) |
| r_busy_o | output | 1 | Right busy flag (master role) |
| r_rvalid_o | output | 1 | Right read output enabled |
| r_rdata_o | output | DATA_W | Right read data |

## Verification
The hardest case to produce is a winner that is decided by history: one side already holds a word when the other side arrives, and the winning side then writes while the loser keeps reading across the moment contention ends. Directed sequences build this up one cycle at a time, with a lone access first, then the late arrival, then the release. A random phase then confines both addresses to a handful of words, so that starts on the same cycle and on different cycles, held contention and address hops happen often. A slave driven by the master's busy flags runs beside the master throughout, so the cascaded write blocking is checked together with the master's own.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic {WIN_LEFT = 1'b0, WIN_RIGHT = 1'b1} side_e;
  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/dpram_start_det.sv
// Flags the cycle in which a side opens a new access (enable rise or address hop).
module dpram_start_det #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              start_o
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q   <= ce_i;
      addr_q <= addr_i;
    end
  end

  assign start_o = ce_i & (~ce_q | (addr_q != addr_i));
endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_i,
  input  logic              r_ce_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              l_start_i,
  input  logic              r_start_i,
  output logic              l_busy_o,
  output logic              r_busy_o
);
  import dpram_pkg::*;

  side_e win_q, win_d;
  logic  clash;

  assign clash = l_ce_i & r_ce_i & (l_addr_i == r_addr_i);

  // later starter loses; a tie goes to the left
  always_comb begin
    win_d = win_q;
    if (l_start_i && r_start_i) win_d = WIN_LEFT;
    else if (l_start_i)         win_d = WIN_RIGHT;
    else if (r_start_i)         win_d = WIN_LEFT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= WIN_LEFT;
    else         win_q <= win_d;
  end

  assign l_busy_o = clash & (win_d == WIN_RIGHT);
  assign r_busy_o = clash & (win_d == WIN_LEFT);
endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  localparam int unsigned NS    = dpram_pkg::NUM_SIDES
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NS-1:0]              wr_i,
  input  logic [NS-1:0]              rd_i,
  input  logic [NS-1:0][ADDR_W-1:0]  addr_i,
  input  logic [NS-1:0][DATA_W-1:0]  wdata_i,
  output logic [NS-1:0]              rvalid_o,
  output logic [NS-1:0][DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // right side is applied last; the arbiter never lets both land on one word
  always_ff @(posedge clk_i) begin
    for (int s = 0; s < NS; s++) begin
      if (wr_i[s]) mem_q[addr_i[s]] <= wdata_i[s];
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rvalid_o[s] <= 1'b0;
        rdata_o[s]  <= '0;
      end else begin
        rvalid_o[s] <= rd_i[s];
        rdata_o[s]  <= rd_i[s] ? mem_q[addr_i[s]] : '0;
      end
    end
  end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned DATA_W    = 8,
  parameter bit          IS_MASTER = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_i,
  input  logic              l_oe_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  output logic              l_rvalid_o,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_ce_i,
  input  logic              r_oe_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_busy_i,
  output logic              r_busy_o,
  output logic              r_rvalid_o,
  output logic [DATA_W-1:0] r_rdata_o
);
  localparam int unsigned NS = dpram_pkg::NUM_SIDES;

  logic [NS-1:0]             ce, oe, we, blk, start, wr, rd, rvalid;
  logic [NS-1:0][ADDR_W-1:0] addr;
  logic [NS-1:0][DATA_W-1:0] wdata, rdata;

  assign ce    = {r_ce_i, l_ce_i};
  assign oe    = {r_oe_i, l_oe_i};
  assign we    = {r_we_i, l_we_i};
  assign addr  = {r_addr_i, l_addr_i};
  assign wdata = {r_wdata_i, l_wdata_i};

  if (IS_MASTER) begin : g_master
    logic [NS-1:0] busy;
    logic          unused_busy_in;
    assign unused_busy_in = l_busy_i ^ r_busy_i;

    for (genvar s = 0; s < NS; s++) begin : g_det
      dpram_start_det #(.ADDR_W(ADDR_W)) i_det (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ce_i    (ce[s]),
        .addr_i  (addr[s]),
        .start_o (start[s])
      );
    end

    dpram_arbiter #(.ADDR_W(ADDR_W)) i_arbiter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .l_ce_i    (ce[0]),
      .r_ce_i    (ce[1]),
      .l_addr_i  (addr[0]),
      .r_addr_i  (addr[1]),
      .l_start_i (start[0]),
      .r_start_i (start[1]),
      .l_busy_o  (busy[0]),
      .r_busy_o  (busy[1])
    );

    assign blk      = busy;
    assign l_busy_o = busy[0];
    assign r_busy_o = busy[1];
  end else begin : g_slave
    assign start    = '0;
    assign blk      = {r_busy_i, l_busy_i};
    assign l_busy_o = 1'b0;
    assign r_busy_o = 1'b0;
  end

  logic unused_start;
  assign unused_start = ^start;

  assign wr = ce & we & ~blk;
  assign rd = ce & oe & ~we;

  dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .rd_i     (rd),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rvalid_o (rvalid),
    .rdata_o  (rdata)
  );

  assign l_rvalid_o = rvalid[0];
  assign r_rvalid_o = rvalid[1];
  assign l_rdata_o  = rdata[0];
  assign r_rdata_o  = rdata[1];
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned DATA_W    = 8,
  parameter bit          IS_MASTER = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_ce_i,
  input logic              l_oe_i,
  input logic              l_we_i,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              l_busy_o,
  input logic              l_rvalid_o,
  input logic [DATA_W-1:0] l_rdata_o,
  input logic              r_ce_i,
  input logic              r_oe_i,
  input logic              r_we_i,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              r_busy_o,
  input logic              r_rvalid_o,
  input logic [DATA_W-1:0] r_rdata_o
);
  AST_BUSY_ONE_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l_busy_o && r_busy_o)); // R4

  AST_L_READ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_ce_i && l_oe_i && !l_we_i) |=> l_rvalid_o); // R2

  AST_R_READ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_ce_i && r_oe_i && !r_we_i) |=> r_rvalid_o); // R2

  AST_L_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_ce_i |=> (!l_rvalid_o && l_rdata_o == '0)); // R3

  AST_R_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_ce_i |=> (!r_rvalid_o && r_rdata_o == '0)); // R3

  if (IS_MASTER) begin : g_m
    AST_BUSY_NEEDS_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (l_busy_o || r_busy_o) |-> (l_ce_i && r_ce_i && l_addr_i == r_addr_i)); // R4

    AST_TIE_TO_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(l_ce_i) && $rose(r_ce_i) && l_addr_i == r_addr_i) |-> r_busy_o); // R6

    AST_LOSER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(l_busy_o) && l_ce_i && r_ce_i && $stable(l_addr_i) && $stable(r_addr_i))
      |-> l_busy_o); // R5
  end else begin : g_s
    AST_SLAVE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !l_busy_o && !r_busy_o); // R10
  end
endmodule

bind dpram_arb dpram_arb_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_MASTER(IS_MASTER)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_ce_i(l_ce_i), .l_oe_i(l_oe_i), .l_we_i(l_we_i), .l_addr_i(l_addr_i),
  .l_busy_o(l_busy_o), .l_rvalid_o(l_rvalid_o), .l_rdata_o(l_rdata_o),
  .r_ce_i(r_ce_i), .r_oe_i(r_oe_i), .r_we_i(r_we_i), .r_addr_i(r_addr_i),
  .r_busy_o(r_busy_o), .r_rvalid_o(r_rvalid_o), .r_rdata_o(r_rdata_o)
);

// File: tb/test_dpram_arb.sv
`timescale 1ns/1ps
module test_dpram_arb;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          l_ce, l_oe, l_we, r_ce, r_oe, r_we, jam;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wd, r_wd;
  logic          m_lb, m_rb, m_lv, m_rv, s_lb, s_rb, s_lv, s_rv;
  logic [DW-1:0] m_ld, m_rd, s_ld, s_rd;

  dpram_arb #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b1)) i_dpram_arb (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_i(l_ce), .l_oe_i(l_oe), .l_we_i(l_we), .l_addr_i(l_addr), .l_wdata_i(l_wd),
    .l_busy_i(jam), .l_busy_o(m_lb), .l_rvalid_o(m_lv), .l_rdata_o(m_ld),
    .r_ce_i(r_ce), .r_oe_i(r_oe), .r_we_i(r_we), .r_addr_i(r_addr), .r_wdata_i(r_wd),
    .r_busy_i(jam), .r_busy_o(m_rb), .r_rvalid_o(m_rv), .r_rdata_o(m_rd)
  );

  dpram_arb #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b0)) i_dpram_slv (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_i(l_ce), .l_oe_i(l_oe), .l_we_i(l_we), .l_addr_i(l_addr), .l_wdata_i(~l_wd),
    .l_busy_i(m_lb), .l_busy_o(s_lb), .l_rvalid_o(s_lv), .l_rdata_o(s_ld),
    .r_ce_i(r_ce), .r_oe_i(r_oe), .r_we_i(r_we), .r_addr_i(r_addr), .r_wdata_i(~r_wd),
    .r_busy_i(m_rb), .r_busy_o(s_rb), .r_rvalid_o(s_rv), .r_rdata_o(s_rd)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int mm [DEPTH];
  int sm [DEPTH];
  bit pce [2];
  int pa  [2];
  bit win_r = 0;
  bit ob_l, ob_r;

  function automatic int seed_val(int a);
    return (a * 7 + 3) & 8'hFF;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check busy, clock, check read outputs
  task automatic step(bit c0, bit w0, bit o0, int a0, int d0,
                      bit c1, bit w1, bit o1, int a1, int d1);
    bit c [2]; bit w [2]; bit o [2]; int a [2]; int d [2];
    bit st [2]; bit cont, eb [2]; bit erv [2]; int emd [2]; int esd [2];
    c = '{c0, c1}; w = '{w0, w1}; o = '{o0, o1}; a = '{a0, a1}; d = '{d0, d1};
    l_ce = c0; l_we = w0; l_oe = o0; l_addr = AW'(a0); l_wd = DW'(d0);
    r_ce = c1; r_we = w1; r_oe = o1; r_addr = AW'(a1); r_wd = DW'(d1);
    #1;
    for (int p = 0; p < 2; p++) st[p] = c[p] && (!pce[p] || a[p] != pa[p]);
    if (st[0] && st[1]) win_r = 0;
    else if (st[0])     win_r = 1;
    else if (st[1])     win_r = 0;
    cont  = c0 && c1 && (a0 == a1);
    eb[0] = cont && win_r;
    eb[1] = cont && !win_r;
    ob_l = m_lb; ob_r = m_rb;
    chk("R4 l_busy", int'(m_lb), int'(eb[0]));
    chk("R4 r_busy", int'(m_rb), int'(eb[1]));
    chk("R10 slave busy", int'({s_lb, s_rb}), 0);
    for (int p = 0; p < 2; p++) begin
      erv[p] = c[p] && o[p] && !w[p];
      emd[p] = erv[p] ? mm[a[p]] : 0;
      esd[p] = erv[p] ? sm[a[p]] : 0;
    end
    for (int p = 0; p < 2; p++) begin
      if (c[p] && w[p] && !eb[p]) begin
        mm[a[p]] = d[p] & 8'hFF;
        sm[a[p]] = ~d[p] & 8'hFF;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2 m_l_rvalid", int'(m_lv), int'(erv[0]));
    chk("R2 m_r_rvalid", int'(m_rv), int'(erv[1]));
    chk("R2 m_l_rdata", int'(m_ld), emd[0]);
    chk("R2 m_r_rdata", int'(m_rd), emd[1]);
    chk("R10 s_l_rdata", int'(s_ld), esd[0]);
    chk("R10 s_r_rdata", int'(s_rd), esd[1]);
    chk("R2 s_rvalid", int'({s_lv, s_rv}), int'({erv[0], erv[1]}));
    for (int p = 0; p < 2; p++) begin pce[p] = c[p]; pa[p] = a[p]; end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    l_ce = 0; l_oe = 0; l_we = 0; l_addr = '0; l_wd = '0;
    r_ce = 0; r_oe = 0; r_we = 0; r_addr = '0; r_wd = '0; jam = 0;
    for (int p = 0; p < 2; p++) begin pce[p] = 0; pa[p] = 0; end
    repeat (3) @(negedge clk);
    chk("R2 reset rvalid", int'({m_lv, m_rv, s_lv, s_rv}), 0);
    chk("R2 reset rdata", int'({m_ld, m_rd}), 0);
    chk("R4 reset busy", int'({m_lb, m_rb}), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: fill the whole array from the left side
    for (int i = 0; i < DEPTH; i++) step(1, 1, 0, i, seed_val(i), 0, 0, 0, 0, 0);
    idle();
    step(0, 0, 0, 0, 0, 1, 0, 1, DEPTH - 1, 0);
    chk("R1 last word via right", int'(m_rd), seed_val(DEPTH - 1));
    step(1, 1, 0, 100, 8'h3C, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 1, 100, 0);
    chk("R1 cross-side readback", int'(m_rd), 8'h3C);

    // R3: standby ignores the write strobe and disables output
    step(0, 1, 1, 100, 8'hFF, 0, 0, 0, 0, 0);
    chk("R3 standby rvalid", int'(m_lv), 0);
    step(0, 0, 0, 0, 0, 1, 0, 1, 100, 0);
    chk("R3 standby write dropped", int'(m_rd), 8'h3C);

    // R6/R7/R8: same-cycle start, both write, then both read
    idle();
    step(1, 1, 0, 5, 8'hA1, 1, 1, 0, 5, 8'hB2);
    chk("R6 tie r_busy", int'(ob_r), 1);
    chk("R6 tie l_busy", int'(ob_l), 0);
    step(1, 0, 1, 5, 0, 1, 0, 1, 5, 0);
    chk("R4 busy held", int'(ob_r), 1);
    chk("R8 left read", int'(m_ld), 8'hA1);
    chk("R8 right read", int'(m_rd), 8'hA1);
    chk("R7 loser write dropped", int'(m_rd), 8'hA1);
    chk("R10 slave cascade", int'(s_rd), 8'h5E);

    // R5/R7: right holds word 9 first, left arrives late and writes
    idle();
    step(0, 0, 0, 0, 0, 1, 0, 1, 9, 0);
    step(1, 1, 0, 9, 8'h44, 1, 0, 1, 9, 0);
    chk("R5 late side busy", int'(ob_l), 1);
    chk("R5 early side free", int'(ob_r), 0);
    step(1, 0, 1, 9, 0, 0, 0, 0, 0, 0);
    chk("R7 late write dropped", int'(m_ld), seed_val(9));

    // R9: winner writes while loser reads, then release
    idle();
    step(0, 0, 0, 0, 0, 1, 0, 1, 9, 0);
    step(1, 0, 1, 9, 0, 1, 1, 0, 9, 8'h5A);
    chk("R9 loser busy", int'(ob_l), 1);
    chk("R9 old data during write", int'(m_ld), seed_val(9));
    step(1, 0, 1, 9, 0, 0, 0, 0, 0, 0);
    chk("R9 new data after release", int'(m_ld), 8'h5A);

    // R11: master ignores busy inputs
    idle();
    jam = 1;
    step(1, 1, 0, 200, 8'h77, 1, 1, 0, 201, 8'h66);
    step(1, 0, 1, 200, 0, 1, 0, 1, 201, 0);
    chk("R11 left write despite busy_i", int'(m_ld), 8'h77);
    chk("R11 right write despite busy_i", int'(m_rd), 8'h66);
    jam = 0;

    // random traffic on a few words for dense contention
    for (int i = 0; i < 4000; i++) begin
      int a0, a1;
      a0 = ($urandom_range(0, 9) == 0) ? $urandom_range(0, DEPTH - 1) : $urandom_range(0, 3);
      a1 = ($urandom_range(0, 9) == 0) ? $urandom_range(0, DEPTH - 1) : $urandom_range(0, 3);
      jam = 1'($urandom_range(0, 1));
      step($urandom_range(0, 3) != 0, $urandom_range(0, 4) < 2, $urandom_range(0, 4) != 0,
           a0, $urandom_range(0, 255),
           $urandom_range(0, 3) != 0, $urandom_range(0, 4) < 2, $urandom_range(0, 4) != 0,
           a1, $urandom_range(0, 255));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule